// File: doc/BRIEF.md
# Performance Event Counter Unit

This block sits beside a processor core and counts what the core reports on a bus of single-cycle event pulses. It has one dedicated 32-bit cycle counter and a parameterized number of general 32-bit event counters. Each event counter is told which event to follow by a 10-bit event number. Privilege-level filter bits limit counting to the levels that software wants to measure. When any counter wraps past all ones, it raises a sticky overflow flag. One shared interrupt line is driven from those flags, gated by per-counter interrupt enables.

Software reaches the unit through a simple register port with a write strobe, an address and a write data bus. Reads are combinational. Enables and interrupt enables are changed through paired set and clear mask registers, so no read-modify-write is needed. Overflow flags are cleared by writing ones. The general counters are reached through a select register and an indirect window. The cycle counter has its own value register. It can advance once every 64 cycles, and it can be stopped while a debug-prohibit input is high.

Register addresses are: 0 control, 1 enable set, 2 enable clear, 3 interrupt-enable set, 4 interrupt-enable clear, 5 overflow flags, 6 software increment, 7 select, 8 selected counter value, 9 selected event type, 10 cycle counter value. All other addresses read 0 and ignore writes.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, every counter, enable mask, interrupt-enable mask, overflow flag, event type and the select register are zero. The interrupt output is low, and the control register reads only the counter-count field.
- R2: In the control register, bit 0 is the global enable, bit 3 is divide-by-64, bit 4 is export enable and bit 5 is debug stop. These bits read back as written. Bits 1 and 2 always read 0. Bits [15:11] read the number of event counters NUM_CNT. All other bits read 0.
- R3: A write to the enable-set register (address 1) or the interrupt-enable-set register (address 3) sets every implemented bit that is 1 in the data. A write to the matching clear register (address 2 or 4) clears those bits. Zero data bits leave their bits unchanged. Either register of a pair reads the current mask. The implemented bits are 0..NUM_CNT-1 for the event counters and bit 31 for the cycle counter. All other bits read 0.
- R4: Overflow flags (address 5) stay set until software clears them. Writing 1 to a bit clears it. Writing 0 to a bit leaves it unchanged.
- R5: The select register (address 7) picks one event counter. Addresses 8 and 9 then read and write that counter's value and event type. If the select value is NUM_CNT or higher, both addresses read 0 and writes to them change nothing.
- R6: An event-type write keeps only the bits in mask 0xC80003FF. Bits [9:0] of the event type are the event number.
- R7: An event counter adds one at a clock edge only when all of these hold: the global enable is 1, its own enable bit is 1, the privilege filter passes, and its event is present in the cycle before that edge. An event number n other than 0x00 and 0x11 means event input bit n.
- R8: The privilege input has four codes: 0 is user, 1 is kernel, 2 is hypervisor and 3 never counts. Event-type bit 30 excludes user. Bit 31 excludes kernel. Bit 27 must be 1 for counting at hypervisor level.
- R9: Event number 0x11 counts every cycle. Event number 0x00 counts writes to the software-increment register (address 6) whose data bit i is 1, where i is the counter's index.
- R10: The cycle counter adds one every cycle while the global enable and enable bit 31 are both 1. With divide-by-64 set, it adds one on every 64th such cycle. With debug stop set, it holds while the debug-prohibit input is high.
- R11: A control write with bit 1 set clears all event counters and leaves the cycle counter unchanged. A control write with bit 2 set clears the cycle counter and its divide-by-64 prescaler.
- R12: A counter stepping from 0xFFFFFFFF to 0 sets its overflow flag, which is bit i for event counter i and bit 31 for the cycle counter. The interrupt output is high exactly while some overflow flag and its interrupt-enable bit are both set.
- R13: A software write of a counter value wins over an increment of that counter in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| events_i | input | EVT_W | Event pulse inputs, one bit per event number |
| priv_i | input | 2 | Current privilege level code |
| dbg_prohibit_i | input | 1 | Debug-prohibit indication |
| irq_o | output | 1 | Shared overflow interrupt |

## Verification
A register write takes effect at the clock edge that samples its strobe, and the new value can be read at once, because the read path is combinational. An event pulse moves its counter at the edge that samples it. The overflow flag and the interrupt change at that same edge when the counter wraps. With divide-by-64 set, the cycle counter changes only at every 64th enabled edge after a cycle-counter clear. The bench changes inputs on the falling edge and reads results half a cycle after the edge that made them. It keeps the event inputs at zero during register writes unless a same-cycle conflict is being tested. It computes expected counts by counting the qualifying edges itself.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int SEL_W    = 5;
  localparam int EVNUM_W  = 10;
  localparam int CYC_BIT  = 31;
  localparam int DIV_LOG2 = 6;
  localparam int CTRL_W   = 6;

  // control bit positions
  localparam int C_EN      = 0;
  localparam int C_EVRST   = 1;
  localparam int C_CYCRST  = 2;
  localparam int C_DIV     = 3;
  localparam int C_DBGSTOP = 5;
  localparam int NF_LSB    = 11;
  localparam int NF_W      = 5;

  // event type fields
  localparam logic [DATA_W-1:0] TYPE_KEEP = 32'hC800_03FF;
  localparam int XK_BIT = 31;
  localparam int XU_BIT = 30;
  localparam int IH_BIT = 27;
  localparam logic [EVNUM_W-1:0] EV_SWINC  = 10'h000;
  localparam logic [EVNUM_W-1:0] EV_CYCLES = 10'h011;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL      = 4'd0,
    A_EN_SET    = 4'd1,
    A_EN_CLR    = 4'd2,
    A_INTEN_SET = 4'd3,
    A_INTEN_CLR = 4'd4,
    A_OVF       = 4'd5,
    A_SWINC     = 4'd6,
    A_SEL       = 4'd7,
    A_EVCNT     = 4'd8,
    A_EVTYPE    = 4'd9,
    A_CYCCNT    = 4'd10
  } pmu_addr_e;

  function automatic logic priv_pass(input logic x_kern, input logic x_user,
                                     input logic i_hyp, input logic [1:0] lvl);
    case (lvl)
      2'd0:    return !x_user;
      2'd1:    return !x_kern;
      2'd2:    return i_hyp;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pmu_evt_counter.sv
`timescale 1ns/1ps
module pmu_evt_counter
  import pmu_pkg::*;
#(
  parameter int EVT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_en_i,
  input  logic [1:0]        priv_i,
  input  logic [EVT_W-1:0]  events_i,
  input  logic              swinc_i,
  input  logic              wr_cnt_i,
  input  logic              wr_type_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] type_o,
  output logic              wrap_o
);
  logic [DATA_W-1:0]  cnt_q, cnt_d, type_q, type_d;
  logic [EVNUM_W-1:0] evnum;
  logic               hit, inc, cnt_upd;

  always_comb begin
    evnum = type_q[EVNUM_W-1:0];
    hit   = 1'b0;
    if (evnum == EV_SWINC) begin
      hit = swinc_i;
    end else if (evnum == EV_CYCLES) begin
      hit = 1'b1;
    end else begin
      for (int i = 0; i < EVT_W; i++) begin
        if (evnum == EVNUM_W'(i)) hit = events_i[i];
      end
    end
    inc = count_en_i & hit &
          priv_pass(type_q[XK_BIT], type_q[XU_BIT], type_q[IH_BIT], priv_i);
  end

  always_comb begin
    cnt_upd = clr_i | wr_cnt_i | inc;
    if (clr_i)         cnt_d = '0;
    else if (wr_cnt_i) cnt_d = wdata_i;
    else               cnt_d = cnt_q + DATA_W'(1);
    wrap_o = inc & ~clr_i & ~wr_cnt_i & (&cnt_q);
    type_d = wdata_i & TYPE_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      type_q <= '0;
    end else begin
      if (cnt_upd)   cnt_q  <= cnt_d;
      if (wr_type_i) type_q <= type_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign type_o = type_q;
endmodule

// File: rtl/pmu_cycle_counter.sv
`timescale 1ns/1ps
module pmu_cycle_counter
  import pmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              div_i,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              wrap_o
);
  logic [DATA_W-1:0]   cnt_q, cnt_d;
  logic [DIV_LOG2-1:0] pre_q, pre_d;
  logic                step, cnt_upd, pre_upd;

  always_comb begin
    step    = run_i & (~div_i | (&pre_q));
    pre_upd = clr_i | run_i;
    pre_d   = clr_i ? '0 : pre_q + DIV_LOG2'(1);
    cnt_upd = clr_i | wr_i | step;
    if (clr_i)     cnt_d = '0;
    else if (wr_i) cnt_d = wdata_i;
    else           cnt_d = cnt_q + DATA_W'(1);
    wrap_o = step & ~clr_i & ~wr_i & (&cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else begin
      if (cnt_upd) cnt_q <= cnt_d;
      if (pre_upd) pre_q <= pre_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/perf_mon_unit.sv
`timescale 1ns/1ps
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int EVT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [EVT_W-1:0]  events_i,
  input  logic [1:0]        priv_i,
  input  logic              dbg_prohibit_i,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] IMPL_MASK =
    (DATA_W'(1) << CYC_BIT) | ((DATA_W'(1) << NUM_CNT) - DATA_W'(1));

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] en_q, en_d, inten_q, inten_d, ovf_q, ovf_d, wrap_vec;
  logic [SEL_W-1:0]  sel_q;
  logic [NUM_CNT-1:0][DATA_W-1:0] cnt_arr, type_arr;
  logic [NUM_CNT-1:0] evt_wrap;
  logic [DATA_W-1:0] cyc_cnt;
  logic cyc_wrap, cyc_run;
  logic wr_ctrl, wr_en_s, wr_en_c, wr_ie_s, wr_ie_c, wr_ovf, wr_swinc;
  logic wr_sel, wr_evcnt, wr_evtype, wr_cyc, evt_clr, cyc_clr;

  always_comb begin
    wr_ctrl   = reg_wr_i && (reg_addr_i == A_CTRL);
    wr_en_s   = reg_wr_i && (reg_addr_i == A_EN_SET);
    wr_en_c   = reg_wr_i && (reg_addr_i == A_EN_CLR);
    wr_ie_s   = reg_wr_i && (reg_addr_i == A_INTEN_SET);
    wr_ie_c   = reg_wr_i && (reg_addr_i == A_INTEN_CLR);
    wr_ovf    = reg_wr_i && (reg_addr_i == A_OVF);
    wr_swinc  = reg_wr_i && (reg_addr_i == A_SWINC);
    wr_sel    = reg_wr_i && (reg_addr_i == A_SEL);
    wr_evcnt  = reg_wr_i && (reg_addr_i == A_EVCNT);
    wr_evtype = reg_wr_i && (reg_addr_i == A_EVTYPE);
    wr_cyc    = reg_wr_i && (reg_addr_i == A_CYCCNT);
    evt_clr   = wr_ctrl & reg_wdata_i[C_EVRST];
    cyc_clr   = wr_ctrl & reg_wdata_i[C_CYCRST];
  end

  // next-state for control and mask registers
  always_comb begin
    ctrl_d = reg_wdata_i[CTRL_W-1:0];
    ctrl_d[C_EVRST]  = 1'b0;
    ctrl_d[C_CYCRST] = 1'b0;
    en_d = en_q;
    if (wr_en_s) en_d = en_q | (reg_wdata_i & IMPL_MASK);
    if (wr_en_c) en_d = en_q & ~reg_wdata_i;
    inten_d = inten_q;
    if (wr_ie_s) inten_d = inten_q | (reg_wdata_i & IMPL_MASK);
    if (wr_ie_c) inten_d = inten_q & ~reg_wdata_i;
    wrap_vec = '0;
    wrap_vec[CYC_BIT] = cyc_wrap;
    for (int i = 0; i < NUM_CNT; i++) wrap_vec[i] = evt_wrap[i];
    ovf_d = ((ovf_q & ~(wr_ovf ? reg_wdata_i : '0)) | wrap_vec) & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      en_q    <= '0;
      inten_q <= '0;
      ovf_q   <= '0;
      sel_q   <= '0;
    end else begin
      if (wr_ctrl)            ctrl_q  <= ctrl_d;
      if (wr_en_s | wr_en_c)  en_q    <= en_d;
      if (wr_ie_s | wr_ie_c)  inten_q <= inten_d;
      ovf_q <= ovf_d;
      if (wr_sel)             sel_q   <= reg_wdata_i[SEL_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_evt
    pmu_evt_counter #(.EVT_W(EVT_W)) i_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .count_en_i(ctrl_q[C_EN] & en_q[g]),
      .priv_i    (priv_i),
      .events_i  (events_i),
      .swinc_i   (wr_swinc & reg_wdata_i[g]),
      .wr_cnt_i  (wr_evcnt & (sel_q == SEL_W'(g))),
      .wr_type_i (wr_evtype & (sel_q == SEL_W'(g))),
      .clr_i     (evt_clr),
      .wdata_i   (reg_wdata_i),
      .cnt_o     (cnt_arr[g]),
      .type_o    (type_arr[g]),
      .wrap_o    (evt_wrap[g])
    );
  end

  assign cyc_run = ctrl_q[C_EN] & en_q[CYC_BIT] &
                   ~(ctrl_q[C_DBGSTOP] & dbg_prohibit_i);

  pmu_cycle_counter i_cyc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (cyc_run),
    .div_i  (ctrl_q[C_DIV]),
    .clr_i  (cyc_clr),
    .wr_i   (wr_cyc),
    .wdata_i(reg_wdata_i),
    .cnt_o  (cyc_cnt),
    .wrap_o (cyc_wrap)
  );

  // read path
  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[CTRL_W-1:0]       = ctrl_q;
        reg_rdata_o[NF_LSB +: NF_W]   = NF_W'(NUM_CNT);
      end
      A_EN_SET, A_EN_CLR:       reg_rdata_o = en_q;
      A_INTEN_SET, A_INTEN_CLR: reg_rdata_o = inten_q;
      A_OVF:                    reg_rdata_o = ovf_q;
      A_SEL:                    reg_rdata_o[SEL_W-1:0] = sel_q;
      A_EVCNT: begin
        for (int i = 0; i < NUM_CNT; i++)
          if (sel_q == SEL_W'(i)) reg_rdata_o = cnt_arr[i];
      end
      A_EVTYPE: begin
        for (int i = 0; i < NUM_CNT; i++)
          if (sel_q == SEL_W'(i)) reg_rdata_o = type_arr[i];
      end
      A_CYCCNT:                 reg_rdata_o = cyc_cnt;
      default:                  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(ovf_q & inten_q);
endmodule

// File: rtl/perf_mon_unit_chk.sv
`timescale 1ns/1ps
module perf_mon_unit_chk
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      reg_wr_i,
  input logic [ADDR_W-1:0]         reg_addr_i,
  input logic [DATA_W-1:0]         reg_wdata_i,
  input logic [DATA_W-1:0]         ovf_i,
  input logic [DATA_W-1:0]         inten_i,
  input logic                      run_en_i,
  input logic [NUM_CNT*DATA_W-1:0] cnt_flat_i,
  input logic                      irq_i
);
  // R11: event-counter clear pulse zeroes every event counter
  p_evt_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == A_CTRL && reg_wdata_i[C_EVRST]) |=> (cnt_flat_i == '0));

  // R4: without a write to the flag register no flag drops
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && reg_addr_i == A_OVF) |=> ((ovf_i & $past(ovf_i)) == $past(ovf_i)));

  // R12: interrupt needs a pending flag
  p_irq_needs_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |-> (ovf_i != '0));

  // R7: with the global enable off and no write, counters hold
  p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en_i && !reg_wr_i) |=> $stable(cnt_flat_i));

  // R3: interrupt enables change only through their set/clear registers
  p_inten_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && (reg_addr_i == A_INTEN_SET || reg_addr_i == A_INTEN_CLR))
      |=> $stable(inten_i));

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_step
    // R7: a counter moves by at most one per cycle unless software writes it
    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_i && (reg_addr_i == A_CTRL || reg_addr_i == A_EVCNT)) |=>
        (cnt_flat_i[g*DATA_W +: DATA_W] == $past(cnt_flat_i[g*DATA_W +: DATA_W]) ||
         cnt_flat_i[g*DATA_W +: DATA_W] == $past(cnt_flat_i[g*DATA_W +: DATA_W]) + DATA_W'(1)));
  end
endmodule

bind perf_mon_unit perf_mon_unit_chk #(.NUM_CNT(NUM_CNT)) i_perf_mon_unit_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .ovf_i      (ovf_q),
  .inten_i    (inten_q),
  .run_en_i   (ctrl_q[0]),
  .cnt_flat_i (cnt_arr),
  .irq_i      (irq_o)
);

// File: tb/test_perf_mon_unit.sv
`timescale 1ns/1ps
module test_perf_mon_unit;
  import pmu_pkg::*;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] events = '0;
  logic [1:0]  priv = '0;
  logic        dbg = 1'b0;
  logic        irq;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  perf_mon_unit #(.NUM_CNT(NC), .EVT_W(32)) i_perf_mon_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .events_i(events),
    .priv_i(priv), .dbg_prohibit_i(dbg), .irq_o(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input pmu_addr_e a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk_rd(input string tag, input pmu_addr_e a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse(input int b, input logic [1:0] p);
    @(negedge clk);
    events[b] = 1'b1; priv = p;
    @(negedge clk);
    events = '0; priv = '0;
  endtask

  function automatic bit exp_pass(input logic [31:0] t, input logic [1:0] p);
    case (p)
      2'd0:    return !t[30];
      2'd1:    return !t[31];
      2'd2:    return t[27];
      default: return 1'b0;
    endcase
  endfunction

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin : main
    int k, exp;
    logic [31:0] t, v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_rd("R1 ctrl", A_CTRL, 32'(NC) << 11);
    chk_rd("R1 en", A_EN_SET, 0);
    chk_rd("R1 inten", A_INTEN_SET, 0);
    chk_rd("R1 ovf", A_OVF, 0);
    chk_rd("R1 cyc", A_CYCCNT, 0);
    chk_rd("R1 sel", A_SEL, 0);
    chk_rd("R1 type0", A_EVTYPE, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 control readback
    wr(A_CTRL, 32'hFFFF_FFFF);
    chk_rd("R2 ctrl", A_CTRL, 32'h0000_0039 | (32'(NC) << 11));
    wr(A_CTRL, 0);

    // R3 masks
    wr(A_EN_SET, 32'hFFFF_FFFF);
    chk_rd("R3 en set", A_EN_CLR, 32'h8000_000F);
    wr(A_EN_CLR, 32'h0000_0005);
    chk_rd("R3 en clr", A_EN_SET, 32'h8000_000A);
    wr(A_INTEN_SET, 32'h8000_0003);
    chk_rd("R3 ie set", A_INTEN_SET, 32'h8000_0003);
    wr(A_INTEN_CLR, 32'h8000_0000);
    chk_rd("R3 ie clr", A_INTEN_CLR, 32'h0000_0003);
    wr(A_EN_CLR, 32'hFFFF_FFFF);

    // R6 event type mask
    wr(A_SEL, 0);
    wr(A_EVTYPE, 32'hFFFF_FFFF);
    chk_rd("R6 type mask", A_EVTYPE, 32'hC800_03FF);
    wr(A_EVTYPE, 0);

    // R9 software increment
    wr(A_EN_SET, 1);
    wr(A_CTRL, 1);
    wr(A_SWINC, 32'hF);
    chk_rd("R9 swinc", A_EVCNT, 1);
    wr(A_SWINC, 32'h2);
    chk_rd("R9 swinc other bit", A_EVCNT, 1);
    // R7 global enable off
    wr(A_CTRL, 0);
    wr(A_SWINC, 1);
    chk_rd("R7 global off", A_EVCNT, 1);
    wr(A_CTRL, 1);

    // R9 cycle event
    wr(A_SEL, 1);
    wr(A_EVTYPE, 32'h11);
    wr(A_EVCNT, 0);
    wr(A_EN_SET, 2);
    repeat (10) @(negedge clk);
    chk_rd("R9 cycle event", A_EVCNT, 10);
    wr(A_EN_CLR, 2);

    // R5 out-of-range select
    wr(A_SEL, NC);
    chk_rd("R5 oor cnt", A_EVCNT, 0);
    chk_rd("R5 oor type", A_EVTYPE, 0);
    wr(A_EVCNT, 32'h123);
    wr(A_EVTYPE, 32'h5);
    wr(A_SEL, 0);
    chk_rd("R5 cnt0 kept", A_EVCNT, 1);
    chk_rd("R5 type0 kept", A_EVTYPE, 0);

    // R8 directed privilege filter
    wr(A_SEL, 2);
    wr(A_EVTYPE, 32'h8000_0005);
    wr(A_EVCNT, 0);
    wr(A_EN_SET, 4);
    pulse(5, 2'd1);
    pulse(5, 2'd0);
    chk_rd("R8 excl kernel", A_EVCNT, 1);
    wr(A_EVTYPE, 32'h5);
    pulse(5, 2'd2);
    chk_rd("R8 hyp not incl", A_EVCNT, 1);
    wr(A_EVTYPE, 32'h0800_0005);
    pulse(5, 2'd2);
    pulse(5, 2'd3);
    chk_rd("R8 hyp incl", A_EVCNT, 2);
    wr(A_EN_CLR, 4);

    // R7 R8 random event streams
    for (int r = 0; r < 3; r++) begin
      k = 1 + int'($urandom % 31);
      if (k == 17) k = 18;
      t = 32'(k) | ($urandom & 32'hC800_0000);
      wr(A_SEL, 2);
      wr(A_EVTYPE, t);
      wr(A_EVCNT, 0);
      wr(A_EN_SET, 4);
      exp = 0;
      for (int c = 0; c < 150; c++) begin
        @(negedge clk);
        events = $urandom;
        priv = 2'($urandom);
        if (events[k] && exp_pass(t, priv)) exp++;
      end
      @(negedge clk);
      events = '0; priv = '0;
      wr(A_EN_CLR, 4);
      chk_rd("R7 random count", A_EVCNT, 32'(exp));
    end

    // R12 event overflow and interrupt
    wr(A_SEL, 3);
    wr(A_EVTYPE, 32'h7);
    wr(A_EVCNT, 32'hFFFF_FFFE);
    wr(A_EN_SET, 8);
    wr(A_INTEN_SET, 8);
    pulse(7, 2'd0);
    chk_rd("R12 pre-wrap cnt", A_EVCNT, 32'hFFFF_FFFF);
    chk_rd("R12 pre-wrap ovf", A_OVF, 0);
    pulse(7, 2'd0);
    chk_rd("R12 wrap cnt", A_EVCNT, 0);
    chk_rd("R12 wrap ovf", A_OVF, 32'h8);
    chk("R12 irq on", {31'b0, irq}, 1);
    // R4 write-one-to-clear
    wr(A_OVF, 0);
    chk_rd("R4 zero write", A_OVF, 32'h8);
    wr(A_OVF, 32'h8);
    chk_rd("R4 one clears", A_OVF, 0);
    chk("R12 irq off", {31'b0, irq}, 0);
    wr(A_INTEN_CLR, 8);
    wr(A_EVCNT, 32'hFFFF_FFFF);
    pulse(7, 2'd0);
    chk_rd("R12 flag no ie", A_OVF, 32'h8);
    chk("R12 irq masked", {31'b0, irq}, 0);
    wr(A_OVF, 32'hFFFF_FFFF);

    // R13 write beats increment
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_EVCNT; reg_wdata = 32'h55; events[7] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; events = '0;
    chk_rd("R13 write priority", A_EVCNT, 32'h55);
    wr(A_EN_CLR, 8);
    wr(A_INTEN_CLR, 32'hFFFF_FFFF);

    // R10 cycle counter
    wr(A_CTRL, 0);
    wr(A_CYCCNT, 0);
    wr(A_EN_SET, 32'h8000_0000);
    wr(A_CTRL, 1);
    repeat (25) @(negedge clk);
    chk_rd("R10 cycles", A_CYCCNT, 25);
    wr(A_CTRL, 32'h0D);
    repeat (202) @(negedge clk);
    chk_rd("R10 div64", A_CYCCNT, 3);
    dbg = 1'b1;
    wr(A_CTRL, 32'h25);
    repeat (20) @(negedge clk);
    chk_rd("R10 dbg stop", A_CYCCNT, 0);
    dbg = 1'b0;
    repeat (5) @(negedge clk);
    chk_rd("R10 dbg release", A_CYCCNT, 5);

    // R11 event clear leaves cycle counter
    wr(A_CTRL, 0);
    reg_addr = A_CYCCNT; #1; v = reg_rdata;
    wr(A_CTRL, 32'h2);
    chk_rd("R11 cyc kept", A_CYCCNT, v);
    chk_rd("R11 cnt3 cleared", A_EVCNT, 0);
    wr(A_SEL, 0);
    chk_rd("R11 cnt0 cleared", A_EVCNT, 0);

    // R12 cycle counter overflow at bit 31
    wr(A_CYCCNT, 32'hFFFF_FFFF);
    wr(A_CTRL, 1);
    repeat (2) @(negedge clk);
    chk_rd("R12 cyc ovf", A_OVF, 32'h8000_0000);
    chk("R12 cyc irq masked", {31'b0, irq}, 0);
    wr(A_INTEN_SET, 32'h8000_0000);
    chk("R12 cyc irq", {31'b0, irq}, 1);
    wr(A_OVF, 32'h8000_0000);
    chk("R12 cyc irq cleared", {31'b0, irq}, 0);

    summary();
    $finish;
  end
endmodule